// File: doc/BRIEF.md
# Processor Halt and Interrupt-Gating Controller

This controller sits next to a small processor core and decides, cycle by cycle, whether a pending interrupt may be taken. It also runs the core's halt states: a low-power stop in which the core's clocks may be gated, a wait state in which fetch pauses until an interrupt arrives, and a debug state entered by a dedicated instruction. The core reports each retiring instruction with a strobe and a small class code. The controller uses the class code, a stop-enable status bit, a debug-enable input, the current interrupt mask and the pending request level to produce its controls.

Interrupts are held off for one more retired instruction after any instruction that may have changed the mask. This lets the core's new mask take effect before an interrupt can slip in. A stop instruction only stops when stop is enabled, and otherwise acts as a no-operation. A debug-entry instruction only enters debug when debug is enabled, and otherwise raises an illegal-instruction trap request.

Top module: `halt_gate_ctrl`

## Requirements
- R1: After reset, the controller is in the running state with irq_accept, fetch_halt, clk_stop_req, dbg_mode and illegal_trap all low and the mask-change window closed.
- R2: When the controller is running, the window is closed and no debug is active, irq_accept is high in the same cycle exactly when irq_req is high and irq_level is strictly greater than irq_mask. Both are unsigned.
- R3: A retire with class code 1 (mask-changing) blocks irq_accept in its own cycle and in every later cycle up to and including the cycle of the next retire. Acceptance is possible again from the cycle after that retire.
- R4: A mask-changing retire that follows inside an open window keeps the window open until the retire after it.
- R5: A retire with class code 2 (stop) while stop_en is high puts the controller in the stopped state from the next cycle, with clk_stop_req and fetch_halt high.
- R6: A stop retire while stop_en is low changes no state and leaves all outputs unchanged. Like any other non-mask retire, it closes an open window.
- R7: A retire with class code 3 (wait) puts the controller in the wait state from the next cycle, with fetch_halt high and clk_stop_req low.
- R8: In the stopped or wait state, an unmasked request raises irq_accept in that same cycle, and the controller is running again from the next cycle. A masked request leaves it halted.
- R9: A retire with class code 4 (debug entry) while dbg_en is high sets dbg_mode and fetch_halt from the next cycle. While dbg_mode is high, irq_accept stays low.
- R10: A debug-entry retire while dbg_en is low raises illegal_trap in the same cycle only, with no state change.
- R11: Retires with class code 5 (null branch) or 0 (other), as well as the unused codes 6 and 7, change no control state.
- R12: Debug mode ends only on dbg_exit: the controller is running from the cycle after dbg_exit is seen in debug. dbg_exit has no effect in any other state.
- R13: Retire strobes are ignored while the controller is stopped, waiting or in debug.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| retire | input | 1 | One instruction retires this cycle |
| iclass | input | 3 | Class of the retiring instruction (0 other, 1 mask-changing, 2 stop, 3 wait, 4 debug entry, 5 null branch) |
| stop_en | input | 1 | Status bit that enables the low-power stop |
| dbg_en | input | 1 | Debug entry permitted |
| dbg_exit | input | 1 | Leave debug mode |
| irq_req | input | 1 | An interrupt is pending |
| irq_level | input | LVL_W | Level of the pending interrupt |
| irq_mask | input | LVL_W | Current interrupt mask level |
| irq_accept | output | 1 | Pending interrupt is taken this cycle |
| fetch_halt | output | 1 | Instruction fetch must pause |
| clk_stop_req | output | 1 | Request to stop the core clocks |
| dbg_mode | output | 1 | Controller is in debug mode |
| illegal_trap | output | 1 | Illegal-instruction trap request |

## Verification
irq_accept and illegal_trap are combinational. They are due in the same cycle as the inputs that cause them, so the bench applies inputs just after the falling edge and samples a nanosecond later, before the next rising edge. fetch_halt, clk_stop_req and dbg_mode come from the state register and change one rising edge after the causing retire, wake-up or dbg_exit. The bench therefore checks them at the sample point of the following cycle, and checks the same signal one cycle earlier to show that it has not yet moved. The mask-change window is observed only through irq_accept, cycle by cycle, across the retires that open and close it.

// File: rtl/hgc_pkg.sv
// Shared types for the halt and interrupt-gating controller.
// Assumes a 3-bit instruction class code supplied by the core's decoder.
package hgc_pkg;

    typedef enum logic [2:0] {
        IC_OTHER = 3'd0,
        IC_MASK  = 3'd1,
        IC_STOP  = 3'd2,
        IC_WAIT  = 3'd3,
        IC_DBG   = 3'd4,
        IC_NULL  = 3'd5
    } iclass_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WAIT = 2'd2,
        ST_DBG  = 2'd3
    } hstate_e;

endpackage

// File: rtl/hgc_irq_gate.sv
// Interrupt gate: compares the pending level against the mask and keeps the
// one-bit window that holds off acceptance after a mask-changing retire.
// Assumes retire is only meaningful while the core is running.
module hgc_irq_gate #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             dbg_active,
    input  logic             retire,
    input  logic             is_mask,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [LVL_W-1:0] irq_mask,
    output logic             accept
);

    logic inhibit_q;
    logic mask_retire;
    logic above_mask;

    // Purpose: a mask change retiring right now already closes the gate.
    assign mask_retire = run && retire && is_mask;
    assign above_mask  = irq_level > irq_mask;

    // Purpose: final acceptance decision for this cycle.
    always_comb begin
        accept = irq_req && above_mask && !inhibit_q && !mask_retire && !dbg_active;
    end

    // Purpose: open the window on a mask-changing retire, close it on any other.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inhibit_q <= 1'b0;
        end else if (run && retire) begin
            inhibit_q <= is_mask;
        end
    end

endmodule

// File: rtl/hgc_state_seq.sv
// Halt-state sequencer: running, stopped, waiting and debug. Steps on retired
// instruction classes while running, and leaves halt states on an accepted
// interrupt or on a debug exit. Assumes accept is already gated by the caller.
module hgc_state_seq
    import hgc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       retire,
    input  logic [2:0] iclass,
    input  logic       stop_en,
    input  logic       dbg_en,
    input  logic       dbg_exit,
    input  logic       accept,
    output logic       run,
    output logic       dbg_active,
    output logic       fetch_halt,
    output logic       clk_stop_req,
    output logic       illegal_trap
);

    hstate_e state_q;
    hstate_e state_d;

    // Purpose: next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (retire) begin
                    if (iclass == IC_STOP && stop_en) begin
                        state_d = ST_STOP;
                    end else if (iclass == IC_WAIT) begin
                        state_d = ST_WAIT;
                    end else if (iclass == IC_DBG && dbg_en) begin
                        state_d = ST_DBG;
                    end
                end
            end
            ST_STOP, ST_WAIT: begin
                if (accept) begin
                    state_d = ST_RUN;
                end
            end
            ST_DBG: begin
                if (dbg_exit) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // Purpose: state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Purpose: decode the state into control outputs.
    always_comb begin
        run          = (state_q == ST_RUN);
        dbg_active   = (state_q == ST_DBG);
        fetch_halt   = (state_q != ST_RUN);
        clk_stop_req = (state_q == ST_STOP);
        illegal_trap = (state_q == ST_RUN) && retire && (iclass == IC_DBG) && !dbg_en;
    end

endmodule

// File: rtl/halt_gate_ctrl.sv
// Top of the halt and interrupt-gating controller. Joins the interrupt gate
// and the halt-state sequencer. Assumes one retire strobe per instruction.
module halt_gate_ctrl
    import hgc_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire,
    input  logic [2:0]       iclass,
    input  logic             stop_en,
    input  logic             dbg_en,
    input  logic             dbg_exit,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [LVL_W-1:0] irq_mask,
    output logic             irq_accept,
    output logic             fetch_halt,
    output logic             clk_stop_req,
    output logic             dbg_mode,
    output logic             illegal_trap
);

    logic run;
    logic dbg_active;
    logic accept;
    logic is_mask;

    // Purpose: class decode for the gate.
    assign is_mask = (iclass == IC_MASK);

    hgc_irq_gate #(.LVL_W(LVL_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .dbg_active (dbg_active),
        .retire     (retire),
        .is_mask    (is_mask),
        .irq_req    (irq_req),
        .irq_level  (irq_level),
        .irq_mask   (irq_mask),
        .accept     (accept)
    );

    hgc_state_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .retire       (retire),
        .iclass       (iclass),
        .stop_en      (stop_en),
        .dbg_en       (dbg_en),
        .dbg_exit     (dbg_exit),
        .accept       (accept),
        .run          (run),
        .dbg_active   (dbg_active),
        .fetch_halt   (fetch_halt),
        .clk_stop_req (clk_stop_req),
        .illegal_trap (illegal_trap)
    );

    assign irq_accept = accept;
    assign dbg_mode   = dbg_active;

endmodule

// File: rtl/hgc_checker.sv
// Property checker for halt_gate_ctrl, attached by bind. Observes ports only.
module hgc_checker #(
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             retire,
    input logic [2:0]       iclass,
    input logic             stop_en,
    input logic             dbg_en,
    input logic             dbg_exit,
    input logic             irq_req,
    input logic [LVL_W-1:0] irq_level,
    input logic [LVL_W-1:0] irq_mask,
    input logic             irq_accept,
    input logic             fetch_halt,
    input logic             clk_stop_req,
    input logic             dbg_mode,
    input logic             illegal_trap
);

    AST_ACCEPT_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |-> (irq_req && irq_level > irq_mask)); // R2
    AST_MASK_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && iclass == 3'd1 && !fetch_halt) |-> !irq_accept); // R3
    AST_MASK_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && iclass == 3'd1 && !fetch_halt) |=> !irq_accept); // R3
    AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && iclass == 3'd2 && stop_en && !fetch_halt) |=> clk_stop_req); // R5
    AST_STOP_HALTS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_req |-> fetch_halt); // R5
    AST_STOP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_stop_req && irq_accept) |=> !clk_stop_req); // R8
    AST_DBG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && iclass == 3'd4 && dbg_en && !fetch_halt) |=> dbg_mode); // R9
    AST_DBG_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode |-> !irq_accept); // R9
    AST_TRAP_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_trap |-> (!dbg_en && retire && !fetch_halt)); // R10
    AST_DBG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_mode && !dbg_exit) |=> dbg_mode); // R12
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_stop_req && !irq_accept) |=> clk_stop_req); // R13

endmodule

bind halt_gate_ctrl hgc_checker #(.LVL_W(LVL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .retire       (retire),
    .iclass       (iclass),
    .stop_en      (stop_en),
    .dbg_en       (dbg_en),
    .dbg_exit     (dbg_exit),
    .irq_req      (irq_req),
    .irq_level    (irq_level),
    .irq_mask     (irq_mask),
    .irq_accept   (irq_accept),
    .fetch_halt   (fetch_halt),
    .clk_stop_req (clk_stop_req),
    .dbg_mode     (dbg_mode),
    .illegal_trap (illegal_trap)
);

// File: tb/halt_gate_ctrl_test.sv
`timescale 1ns/1ps
module halt_gate_ctrl_test;

    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          retire;
    logic [2:0]    iclass;
    logic          stop_en;
    logic          dbg_en;
    logic          dbg_exit;
    logic          irq_req;
    logic [LW-1:0] irq_level;
    logic [LW-1:0] irq_mask;
    logic          irq_accept;
    logic          fetch_halt;
    logic          clk_stop_req;
    logic          dbg_mode;
    logic          illegal_trap;

    // values copied to the inputs at the next falling edge
    logic          b_req, b_stop_en, b_dbg_en, b_exit;
    logic [LW-1:0] b_lvl, b_msk;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    halt_gate_ctrl #(.LVL_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .retire(retire), .iclass(iclass),
        .stop_en(stop_en), .dbg_en(dbg_en), .dbg_exit(dbg_exit),
        .irq_req(irq_req), .irq_level(irq_level), .irq_mask(irq_mask),
        .irq_accept(irq_accept), .fetch_halt(fetch_halt),
        .clk_stop_req(clk_stop_req), .dbg_mode(dbg_mode),
        .illegal_trap(illegal_trap)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    // apply a cycle's inputs after the falling edge, then settle
    task automatic setin(input logic r, input logic [2:0] c);
        @(negedge clk);
        retire    = r;
        iclass    = c;
        irq_req   = b_req;
        irq_level = b_lvl;
        irq_mask  = b_msk;
        stop_en   = b_stop_en;
        dbg_en    = b_dbg_en;
        dbg_exit  = b_exit;
        #1;
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: got=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; retire = 1'b0; iclass = 3'd0; stop_en = 1'b0; dbg_en = 1'b0;
        dbg_exit = 1'b0; irq_req = 1'b0; irq_level = '0; irq_mask = '0;
        b_req = 1'b0; b_lvl = '0; b_msk = '0; b_stop_en = 1'b0; b_dbg_en = 1'b0; b_exit = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        setin(1'b0, 3'd0);
        // R1 reset state
        chk("R1 irq_accept", irq_accept, 1'b0);
        chk("R1 fetch_halt", fetch_halt, 1'b0);
        chk("R1 clk_stop_req", clk_stop_req, 1'b0);
        chk("R1 dbg_mode", dbg_mode, 1'b0);
        chk("R1 illegal_trap", illegal_trap, 1'b0);

        // R2 full sweep of request, level and mask
        for (int m = 0; m < 8; m++) begin
            for (int l = 0; l < 8; l++) begin
                for (int q = 0; q < 2; q++) begin
                    b_req = q[0]; b_lvl = l[LW-1:0]; b_msk = m[LW-1:0];
                    setin(1'b0, 3'd0);
                    chk("R2 level compare", irq_accept, (q == 1) && (l > m));
                end
            end
        end

        // R3 window opened by a mask change, closed by the next retire
        b_req = 1'b1; b_lvl = 3'd7; b_msk = 3'd0;
        setin(1'b1, 3'd1);
        chk("R3 same cycle", irq_accept, 1'b0);
        setin(1'b0, 3'd0);
        chk("R3 idle in window", irq_accept, 1'b0);
        setin(1'b0, 3'd0);
        chk("R3 still in window", irq_accept, 1'b0);
        setin(1'b1, 3'd5);
        chk("R3 closing retire cycle", irq_accept, 1'b0);
        setin(1'b0, 3'd0);
        chk("R3 reopened", irq_accept, 1'b1);

        // R4 back-to-back mask changes
        setin(1'b1, 3'd1);
        chk("R4 first", irq_accept, 1'b0);
        setin(1'b1, 3'd1);
        chk("R4 second", irq_accept, 1'b0);
        setin(1'b1, 3'd0);
        chk("R4 extended", irq_accept, 1'b0);
        setin(1'b0, 3'd0);
        chk("R4 closed", irq_accept, 1'b1);

        // R6 stop while disabled acts as a no-op and closes the window
        b_stop_en = 1'b0;
        setin(1'b1, 3'd1);
        chk("R6 window open", irq_accept, 1'b0);
        setin(1'b1, 3'd2);
        chk("R6 stop retire", irq_accept, 1'b0);
        setin(1'b0, 3'd0);
        chk("R6 window closed", irq_accept, 1'b1);
        chk("R6 no clock stop", clk_stop_req, 1'b0);
        chk("R6 no fetch halt", fetch_halt, 1'b0);
        b_req = 1'b0;

        // R11 null-branch and unused codes change nothing
        for (int c = 5; c < 8; c++) begin
            setin(1'b1, c[2:0]);
            setin(1'b0, 3'd0);
            chk("R11 fetch_halt", fetch_halt, 1'b0);
            chk("R11 dbg_mode", dbg_mode, 1'b0);
        end

        // R5 enabled stop
        b_stop_en = 1'b1;
        setin(1'b1, 3'd2);
        chk("R5 not yet stopped", clk_stop_req, 1'b0);
        setin(1'b0, 3'd0);
        chk("R5 clk_stop_req", clk_stop_req, 1'b1);
        chk("R5 fetch_halt", fetch_halt, 1'b1);

        // R13 retire ignored while stopped
        b_dbg_en = 1'b1;
        setin(1'b1, 3'd4);
        setin(1'b0, 3'd0);
        chk("R13 no debug from stop", dbg_mode, 1'b0);
        chk("R13 still stopped", clk_stop_req, 1'b1);
        b_dbg_en = 1'b0;

        // R8 masked request keeps stop, unmasked one wakes
        b_req = 1'b1; b_lvl = 3'd2; b_msk = 3'd5;
        setin(1'b0, 3'd0);
        chk("R8 masked no accept", irq_accept, 1'b0);
        setin(1'b0, 3'd0);
        chk("R8 masked stays stopped", clk_stop_req, 1'b1);
        b_msk = 3'd1;
        setin(1'b0, 3'd0);
        chk("R8 wake accept", irq_accept, 1'b1);
        chk("R8 stopped during accept", clk_stop_req, 1'b1);
        b_req = 1'b0;
        setin(1'b0, 3'd0);
        chk("R8 running after wake", clk_stop_req, 1'b0);
        chk("R8 fetch resumed", fetch_halt, 1'b0);

        // R7 wait
        setin(1'b1, 3'd3);
        setin(1'b0, 3'd0);
        chk("R7 fetch_halt", fetch_halt, 1'b1);
        chk("R7 clocks run", clk_stop_req, 1'b0);
        b_req = 1'b1; b_lvl = 3'd3; b_msk = 3'd2;
        setin(1'b0, 3'd0);
        chk("R8 wait accept", irq_accept, 1'b1);
        b_req = 1'b0;
        setin(1'b0, 3'd0);
        chk("R8 wait left", fetch_halt, 1'b0);

        // R10 debug entry while disabled
        b_dbg_en = 1'b0;
        setin(1'b1, 3'd4);
        chk("R10 trap raised", illegal_trap, 1'b1);
        setin(1'b0, 3'd0);
        chk("R10 trap single cycle", illegal_trap, 1'b0);
        chk("R10 no debug", dbg_mode, 1'b0);

        // R12 exit outside debug has no effect
        b_exit = 1'b1;
        setin(1'b0, 3'd0);
        b_exit = 1'b0;
        setin(1'b0, 3'd0);
        chk("R12 exit ignored", fetch_halt, 1'b0);

        // R9 debug entry and suppression
        b_dbg_en = 1'b1;
        setin(1'b1, 3'd4);
        chk("R9 trap absent", illegal_trap, 1'b0);
        chk("R9 not yet debug", dbg_mode, 1'b0);
        b_req = 1'b1; b_lvl = 3'd7; b_msk = 3'd0;
        setin(1'b0, 3'd0);
        chk("R9 dbg_mode", dbg_mode, 1'b1);
        chk("R9 fetch_halt", fetch_halt, 1'b1);
        chk("R9 accept suppressed", irq_accept, 1'b0);
        setin(1'b1, 3'd2);
        chk("R12 held in debug", dbg_mode, 1'b1);
        b_exit = 1'b1;
        setin(1'b0, 3'd0);
        chk("R12 exit cycle", dbg_mode, 1'b1);
        b_exit = 1'b0;
        setin(1'b0, 3'd0);
        chk("R12 left debug", dbg_mode, 1'b0);
        chk("R12 accept returns", irq_accept, 1'b1);
        chk("R13 stop during debug ignored", clk_stop_req, 1'b0);
        b_req = 1'b0;
        setin(1'b0, 3'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule